// File: doc/BRIEF.md
# Timestamp-Based Packet Delay Line

This block holds every packet of one output path for a programmable number of clock cycles before handing it on. A free-running cycle counter supplies the current time. When the first beat of a packet is accepted, the block computes a release stamp equal to the current time plus the delay setting. The packet's beats are kept in a payload FIFO, and its stamp is kept in a parallel FIFO of release times.

A packet becomes eligible to leave once the counter has reached its stamp. Packets always leave in the order they arrived. Because stamps and time are compared by the sign of their difference, the comparison stays correct when the counter wraps.

The delay setting is a register written through a one-cycle write strobe, and a new value applies only to packets stamped after the write. The longest delay that can actually be reached is bounded by how much the two FIFOs can hold. When either FIFO has no room, the input stalls the sender instead of dropping beats.

Top module: `pdl_delay_line`

## Requirements
- R1: While reset is applied and right after it, out_valid is 0, line_empty is 1 and the delay setting is 0.
- R2: A packet whose first beat is accepted in cycle k, while the delay setting is D, is first presented (out_valid rises for it) in cycle k+D. This holds provided its last beat was accepted before cycle k+D and the preceding packet has fully left.
- R3: A packet is never presented before its last beat has been accepted. With D = 0, a packet whose last beat is accepted in cycle L is presented in cycle L+1 when nothing precedes it.
- R4: Packets leave strictly in arrival order. A packet with a short delay that follows one with a long delay is first presented in the cycle after the earlier packet's last beat leaves, or at its own release cycle if that is later.
- R5: Every accepted beat leaves exactly once, with unchanged data and end-of-packet flag (out_last marks the final beat), in acceptance order.
- R6: A write on cfg_wr_en takes effect from the next cycle. A packet whose first beat is accepted in the same cycle as the write still uses the previous delay.
- R7: in_ready is 0 and line_full is 1 whenever the payload FIFO holds PAY_DEPTH beats or the stamp FIFO holds PKT_DEPTH complete packets. No beat is lost or truncated under this backpressure.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data and out_last do not change.
- R9: Release decisions stay correct across wraparound of the TS_W-bit counter, as long as no queued packet is more than 2^(TS_W-1) cycles past its stamp.
- R10: line_empty is 1 exactly when the payload FIFO holds no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Write strobe for the delay setting |
| cfg_wr_delay | input | TS_W | New delay in clock cycles |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | DATA_W | Input beat payload |
| in_last | input | 1 | Input beat ends its packet |
| out_valid | output | 1 | Head beat of a released packet available |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | DATA_W | Output beat payload |
| out_last | output | 1 | Output beat ends its packet |
| line_empty | output | 1 | No beat stored |
| line_full | output | 1 | Storage exhausted, input stalled |

## Verification
Two events can fall in the same cycle: a delay write and the acceptance of a packet's first beat. The bench drives both in one cycle and requires that packet to keep the old delay while the following packet takes the new one.

A second collision is the last beat of one packet leaving while a younger packet's stamp has already expired. The bench provokes it by queuing a long-delay packet ahead of a short-delay one. The younger packet must then appear exactly one cycle after the older one finishes.

Every packet's presentation cycle is predicted as the maximum of three values: its own release cycle, the cycle after its last input beat, and the cycle after the previous packet's last output beat. That prediction is compared exactly, including over long random runs in which the narrow counter wraps several times.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  localparam int unsigned PDL_DATA_W_DEF    = 16;
  localparam int unsigned PDL_TS_W_DEF      = 32;
  localparam int unsigned PDL_PAY_DEPTH_DEF = 32;
  localparam int unsigned PDL_PKT_DEPTH_DEF = 8;
endpackage

// File: rtl/pdl_sys_timer.sv
module pdl_sys_timer #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now
);
  logic [TS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign now = cnt_q;
endmodule

// File: rtl/pdl_fifo.sv
module pdl_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  assign pop_data = mem[rd_q];
endmodule

// File: rtl/pdl_delay_line.sv
module pdl_delay_line
  import pdl_pkg::*;
#(
  parameter int unsigned DATA_W    = PDL_DATA_W_DEF,
  parameter int unsigned TS_W      = PDL_TS_W_DEF,
  parameter int unsigned PAY_DEPTH = PDL_PAY_DEPTH_DEF,
  parameter int unsigned PKT_DEPTH = PDL_PKT_DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [TS_W-1:0]   cfg_wr_delay,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              line_empty,
  output logic              line_full
);
  localparam int unsigned BEAT_W = DATA_W + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [TS_W-1:0]   now_w;
  logic [TS_W-1:0]   delay_q, delay_d;
  logic [TS_W-1:0]   rel_q, rel_d;
  logic              mid_q, mid_d;
  logic              in_fire, out_fire;
  logic [TS_W-1:0]   stamp_in, head_stamp, age;
  logic              head_due;
  logic              pay_empty, pay_full, stamp_empty, stamp_full;
  logic [BEAT_W-1:0] pay_head;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pdl_sys_timer #(.TS_W(TS_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_core_n),
    .now  (now_w)
  );

  assign line_full = pay_full || stamp_full;
  assign in_ready  = !line_full;
  assign in_fire   = in_valid && in_ready;

  // stamp taken on the first beat, committed with the last beat
  assign stamp_in = mid_q ? rel_q : (now_w + delay_q);

  always_comb begin
    delay_d = cfg_wr_en ? cfg_wr_delay : delay_q;
    rel_d   = rel_q;
    mid_d   = mid_q;
    if (in_fire) begin
      rel_d = stamp_in;
      mid_d = !in_last;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      delay_q <= '0;
      rel_q   <= '0;
      mid_q   <= 1'b0;
    end else begin
      delay_q <= delay_d;
      rel_q   <= rel_d;
      mid_q   <= mid_d;
    end
  end

  pdl_fifo #(.WIDTH(BEAT_W), .DEPTH(PAY_DEPTH)) u_pay_fifo (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .push     (in_fire),
    .push_data({in_last, in_data}),
    .pop      (out_fire),
    .pop_data (pay_head),
    .empty    (pay_empty),
    .full     (pay_full)
  );

  pdl_fifo #(.WIDTH(TS_W), .DEPTH(PKT_DEPTH)) u_stamp_fifo (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .push     (in_fire && in_last),
    .push_data(stamp_in),
    .pop      (out_fire && out_last),
    .pop_data (head_stamp),
    .empty    (stamp_empty),
    .full     (stamp_full)
  );

  // due when (now - release) is non-negative modulo 2^TS_W
  assign age       = now_w - head_stamp;
  assign head_due  = !age[TS_W-1];
  assign out_valid = !stamp_empty && head_due;
  assign out_fire  = out_valid && out_ready;
  assign out_data  = pay_head[DATA_W-1:0];
  assign out_last  = pay_head[DATA_W];
  assign line_empty = pay_empty;
endmodule

// File: rtl/pdl_delay_line_chk.sv
module pdl_delay_line_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TS_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TS_W-1:0]   now,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              stamp_empty,
  input logic              pay_empty
);
  logic past_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  // R2
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> now == TS_W'($past(now) + TS_W'(1)));

  // R3
  packet_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !stamp_empty);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_empty |-> !out_valid);
endmodule

bind pdl_delay_line pdl_delay_line_chk #(.DATA_W(DATA_W), .TS_W(TS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .now        (now_w),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_last    (in_last),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .stamp_empty(stamp_empty),
  .pay_empty  (pay_empty)
);

// File: tb/pdl_delay_line_test.sv
module pdl_delay_line_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TW = 10;
  localparam int PD = 32;
  localparam int KD = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [TW-1:0] cfg_wr_delay = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          out_last;
  logic          line_empty, line_full;

  pdl_delay_line #(.DATA_W(DW), .TS_W(TW), .PAY_DEPTH(PD), .PKT_DEPTH(KD)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_delay(cfg_wr_delay),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .line_empty(line_empty), .line_full(line_full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int max3(int a, int b, int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // bench model
  int    exp_beat[$];
  int    pk_first[$], pk_d[$], pk_last[$];
  string pk_tag[$];
  int    model_delay = 0;
  bit    mon_en = 0, in_mid = 0, head_seen = 0, stall_prev = 0;
  int    cur_first = 0, cur_d = 0, prev_out_last = -1000, acc_beats = 0;
  int    stall_val = 0;
  string cur_tag = "R2";
  bit    rnd_ready = 0;
  int    seq = 1;

  always @(negedge clk) begin
    if (mon_en) begin
      if (in_valid && in_ready) begin
        exp_beat.push_back({15'd0, in_last, in_data});
        acc_beats++;
        if (!in_mid) begin cur_first = cyc; cur_d = model_delay; end
        in_mid = !in_last;
        if (in_last) begin
          pk_first.push_back(cur_first); pk_d.push_back(cur_d);
          pk_last.push_back(cyc); pk_tag.push_back(cur_tag);
        end
      end
      if (cfg_wr_en) model_delay = int'(cfg_wr_delay);
      if (stall_prev)
        check(out_valid && ({15'd0, out_last, out_data} == stall_val), "R8",
              "stalled beat changed", {15'd0, out_last, out_data}, stall_val);
      stall_prev = out_valid && !out_ready;
      stall_val  = {15'd0, out_last, out_data};
      if (out_valid) begin
        if (pk_first.size() == 0) check(0, "R3", "valid with no complete packet", 1, 0);
        else begin
          if (!head_seen) begin
            int e;
            e = max3(pk_first[0] + pk_d[0], pk_last[0] + 1, prev_out_last + 1);
            check(cyc == e, pk_tag[0], "release cycle", cyc, e);
            head_seen = 1;
          end
          if (out_ready) begin
            int eb;
            eb = (exp_beat.size() != 0) ? exp_beat.pop_front() : -1;
            check({15'd0, out_last, out_data} == eb, "R5", "beat",
                  {15'd0, out_last, out_data}, eb);
            if (out_last) begin
              prev_out_last = cyc;
              void'(pk_first.pop_front()); void'(pk_d.pop_front());
              void'(pk_last.pop_front()); void'(pk_tag.pop_front());
              head_seen = 0;
            end
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rnd_ready) out_ready = ($urandom % 4) != 0;
  end

  task automatic cfg_write(int v);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wr_delay = TW'(v);
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic send_pkt(int len, string tag);
    @(posedge clk); #1;
    cur_tag = tag;
    for (int b = 0; b < len; b++) begin
      in_valid = 1'b1; in_data = DW'(seq); in_last = (b == len - 1);
      seq++;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    while (pk_first.size() != 0 || in_mid) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R5 watchdog expired: cycles %0d expected below %0d", cyc, 100000);
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(line_empty == 1'b1, "R1", "line_empty in reset", line_empty, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    mon_en = 1; out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && line_empty == 1'b1, "R1", "idle after reset",
          {out_valid, line_empty}, 1);

    // zero delay (reset value)
    send_pkt(1, "R3"); drain();
    send_pkt(3, "R3"); drain();
    // plain delay
    cfg_write(20); send_pkt(2, "R2"); drain();
    // head-of-line: long then short
    cfg_write(40); send_pkt(1, "R2");
    cfg_write(2);  send_pkt(2, "R4"); drain();
    // write in same cycle as first beat
    @(posedge clk); #1;
    cur_tag = "R6";
    cfg_wr_en = 1'b1; cfg_wr_delay = TW'(30);
    in_valid = 1'b1; in_data = DW'(seq); in_last = 1'b1; seq++;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    send_pkt(1, "R6"); drain();

    // backpressure: stamp FIFO limit
    cfg_write(3); out_ready = 1'b0; acc_beats = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      cur_tag = "R7"; in_valid = 1'b1; in_data = DW'(seq); in_last = 1'b1;
      @(negedge clk); if (in_ready) seq++;
    end
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    check(acc_beats == KD, "R7", "packets accepted", acc_beats, KD);
    check(in_ready == 1'b0 && line_full == 1'b1, "R7", "stall at packet limit", in_ready, 0);
    check(line_empty == 1'b0, "R10", "line_empty with data", line_empty, 0);
    out_ready = 1'b1; drain();

    // backpressure: payload FIFO limit with 6-beat packets
    out_ready = 1'b0; acc_beats = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = DW'(seq); in_last = ((acc_beats % 6) == 5);
      @(negedge clk); if (in_ready) seq++;
    end
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    check(acc_beats == PD, "R7", "beats accepted", acc_beats, PD);
    check(in_ready == 1'b0, "R7", "stall at beat limit", in_ready, 0);
    @(posedge clk); #1; out_ready = 1'b1;
    while (in_mid) begin
      in_valid = 1'b1; in_data = DW'(seq); in_last = ((acc_beats % 6) == 5);
      do @(negedge clk); while (!in_ready);
      seq++;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
    drain();

    // random phase; the 10-bit counter wraps several times
    rnd_ready = 1;
    for (int p = 0; p < 300; p++) begin
      if (($urandom % 5) == 0) cfg_write(int'($urandom % 51));
      repeat ($urandom % 4) @(posedge clk);
      send_pkt(1 + int'($urandom % 4), (cyc > 1100) ? "R9" : "R2");
    end
    drain();
    rnd_ready = 0; #2; out_ready = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(pk_first.size() == 0 && exp_beat.size() == 0, "R5", "undelivered beats",
          exp_beat.size(), 0);
    check(line_empty == 1'b1, "R10", "line_empty after drain", line_empty, 1);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R10", "idle after drain", out_valid, 0);
    check(cyc > 1100, "R9", "run long enough to wrap", cyc, 1100);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule